// File: doc/BRIEF.md
# FIFO Level and Interrupt Generator

This block holds the transmit and receive queues of a serial controller and turns their fill levels into interrupt requests. Each queue has a fixed byte budget (16 bytes by default), so the number of entries it accepts depends on the selected word size: 16 entries for 8-bit words, 8 for 16-bit words and 4 for 32-bit words. The register bank pushes into the transmit queue and pops from the receive queue. The shift engine does the reverse.

For each direction a 2-bit mode picks the fill condition that raises that direction's interrupt. The block also keeps three sticky error flags: receive overflow, transmit underrun and repeated frame sync. A fault interrupt is raised when any flag is set and its enable bit is on. A status word reports the two levels, receive-empty and the three flags at fixed bit positions that the register decoder relies on. Changing the word size empties both queues.

Top module: `sfifo_irq_gen`

## Requirements
- R1: Capacity in entries is 16, 8 or 4 for `word_sel` 0, 1 or 2, and value 3 behaves as 2. A push while a queue holds that many entries is dropped, and the level does not change.
- R2: `status` has receive-empty at bit 5, overflow at bit 6, underrun at bit 8, frame error at bit 12, the transmit level at bits 20:16 and the receive level at bits 28:24. Every other bit reads 0.
- R3: `rx_irq` by `rx_irq_mode`: 0 = receive level is 0; 1 = level is not 0; 2 = level is at least half the capacity; 3 = level equals the capacity.
- R4: `tx_irq` by `tx_irq_mode`: 0 = transmit level is 0 and `tx_busy` is low; 1 = level is 0; 2 = free slots are at least half the capacity; 3 = at least one slot is free.
- R5: Entries leave in arrival order. Each stored word is masked to the low 8, 16 or 32 bits for the current word size. A successful pop places the head word on the read-data output one cycle later, and the output holds that word until the next successful pop.
- R6: A pop from an empty queue leaves the read-data output and the level unchanged.
- R7: An `rx_wr` while the receive queue is full sets the overflow flag. The flag stays set until `err_clr[0]` is pulsed. A new overflow in the same cycle as a clear leaves the flag set.
- R8: A `tx_rd` while the transmit queue is empty sets the underrun flag only when `framed_en` is 1. The flag clears with `err_clr[1]`.
- R9: A `sync_repeat` pulse sets the frame error flag. The flag clears with `err_clr[2]`.
- R10: `fault_irq` is high when any flag is set together with its enable in `err_irq_en`. Bit 0 enables overflow, bit 1 underrun and bit 2 frame error.
- R11: In a cycle where `word_sel` differs from the registered word size, both levels become 0. Pushes and pops in that cycle have no effect, and the error flags are not cleared.
- R12: After reset both levels, all flags and both read-data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_sel | input | 2 | Word size: 0 = 8, 1 = 16, 2/3 = 32 bits |
| framed_en | input | 1 | Framed operation; enables underrun detection |
| tx_busy | input | 1 | Shift engine still shifting a word |
| tx_irq_mode | input | 2 | Transmit interrupt condition select |
| rx_irq_mode | input | 2 | Receive interrupt condition select |
| err_irq_en | input | 3 | Fault enables {frame, underrun, overflow} |
| err_clr | input | 3 | Flag clear strobes {frame, underrun, overflow} |
| tx_wr | input | 1 | Push into transmit queue (register bank) |
| tx_wr_data | input | 32 | Transmit push data |
| tx_rd | input | 1 | Pop from transmit queue (shift engine) |
| tx_rd_data | output | 32 | Last word popped from transmit queue |
| rx_wr | input | 1 | Push into receive queue (shift engine) |
| rx_wr_data | input | 32 | Receive push data |
| rx_rd | input | 1 | Pop from receive queue (register bank) |
| rx_rd_data | output | 32 | Last word popped from receive queue |
| sync_repeat | input | 1 | Pulse: extra frame sync seen within a frame |
| status | output | 32 | Levels and flags |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |
| fault_irq | output | 1 | Error interrupt |

## Verification
The assertions assume that `word_sel` changes only between clock edges and that every strobe is a synchronous one-cycle-or-longer level. They also assume that the capacity the queues see always comes from the registered word size, so a level never exceeds the capacity except through a word-size change, and that change flushes the queue. The stimulus drives every input just after a falling edge and holds it through the next rising edge. It changes `word_sel` only rarely, so the queues have time to fill to their limits between flushes, and it mixes phases that are mostly-push, balanced and mostly-pop, so that the full, empty and simultaneous push-and-pop cases all occur.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    localparam int ERR_N   = 3;
    localparam int ERR_OVF = 0;
    localparam int ERR_UR  = 1;
    localparam int ERR_FRM = 2;

    localparam int ST_RXEMPTY = 5;
    localparam int ST_OVF     = 6;
    localparam int ST_UR      = 8;
    localparam int ST_FRM     = 12;
    localparam int ST_TXLVL   = 16;
    localparam int ST_RXLVL   = 24;
    localparam int ST_LVL_W   = 5;

    typedef enum logic [1:0] {
        IRQ_M0 = 2'd0,
        IRQ_M1 = 2'd1,
        IRQ_M2 = 2'd2,
        IRQ_M3 = 2'd3
    } irq_mode_e;

    function automatic int unsigned word_shift(input logic [1:0] ws);
        case (ws)
            2'd0:    return 0;
            2'd1:    return 1;
            default: return 2;
        endcase
    endfunction
endpackage

// File: rtl/sfifo_queue.sv
module sfifo_queue #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int LVL_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [LVL_W-1:0]  cap,
    input  logic [DATA_W-1:0] mask,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [LVL_W-1:0]  level,
    output logic [DATA_W-1:0] pop_data,
    output logic              push_full,
    output logic              pop_empty
);
    typedef struct packed {
        logic [PTR_W-1:0]  wr;
        logic [PTR_W-1:0]  rd;
        logic [LVL_W-1:0]  lvl;
        logic [DATA_W-1:0] dout;
    } q_state_t;

    q_state_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;
    logic [PTR_W-1:0] last_idx;

    always_comb begin
        last_idx  = PTR_W'(cap - 1'b1);
        push_ok   = push && !flush && (st_q.lvl < cap);
        pop_ok    = pop && !flush && (st_q.lvl != '0);
        push_full = push && !flush && (st_q.lvl >= cap);
        pop_empty = pop && !flush && (st_q.lvl == '0);
        st_d = st_q;
        if (flush) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.lvl = '0;
        end else begin
            if (push_ok) begin
                st_d.wr = (st_q.wr == last_idx) ? '0 : st_q.wr + 1'b1;
            end
            if (pop_ok) begin
                st_d.rd   = (st_q.rd == last_idx) ? '0 : st_q.rd + 1'b1;
                st_d.dout = mem_q[st_q.rd];
            end
            st_d.lvl = st_q.lvl + LVL_W'(push_ok) - LVL_W'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wr] <= push_data & mask;
    end

    assign level    = st_q.lvl;
    assign pop_data = st_q.dout;

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lvl <= cap); // R1
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && st_q.lvl == cap) |=> $stable(st_q.lvl)); // R1
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && st_q.lvl == '0) |=> ($stable(pop_data) && st_q.lvl == '0)); // R6
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.lvl == '0)); // R11
endmodule

// File: rtl/sfifo_irq_eval.sv
module sfifo_irq_eval
    import sfifo_pkg::*;
#(
    parameter bit IS_TX = 1'b0,
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0] cap,
    input  logic [1:0]       mode,
    input  logic             idle,
    output logic             irq
);
    logic [LVL_W-1:0] half;
    logic [LVL_W-1:0] free;
    logic is_empty;

    assign half     = cap >> 1;
    assign free     = cap - lvl;
    assign is_empty = (lvl == '0);

    generate
        if (IS_TX) begin : g_tx
            always_comb begin
                case (irq_mode_e'(mode))
                    IRQ_M0:  irq = is_empty && idle;
                    IRQ_M1:  irq = is_empty;
                    IRQ_M2:  irq = (free >= half);
                    default: irq = (lvl < cap);
                endcase
            end
        end else begin : g_rx
            always_comb begin
                case (irq_mode_e'(mode))
                    IRQ_M0:  irq = is_empty && idle;
                    IRQ_M1:  irq = !is_empty;
                    IRQ_M2:  irq = (lvl >= half);
                    default: irq = (lvl == cap);
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/sfifo_irq_gen.sv
module sfifo_irq_gen
    import sfifo_pkg::*;
#(
    parameter int FIFO_BYTES = 16,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        word_sel,
    input  logic              framed_en,
    input  logic              tx_busy,
    input  logic [1:0]        tx_irq_mode,
    input  logic [1:0]        rx_irq_mode,
    input  logic [2:0]        err_irq_en,
    input  logic [2:0]        err_clr,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wr_data,
    input  logic              tx_rd,
    output logic [DATA_W-1:0] tx_rd_data,
    input  logic              rx_wr,
    input  logic [DATA_W-1:0] rx_wr_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rd_data,
    input  logic              sync_repeat,
    output logic [31:0]       status,
    output logic              tx_irq,
    output logic              rx_irq,
    output logic              fault_irq
);
    localparam int PTR_W = $clog2(FIFO_BYTES);
    localparam int LVL_W = PTR_W + 1;

    typedef struct packed {
        logic [1:0]       ws;
        logic [ERR_N-1:0] err;
    } top_state_t;

    top_state_t st_d, st_q;
    logic flush;
    logic [LVL_W-1:0] cap, tx_lvl, rx_lvl;
    logic [DATA_W-1:0] mask;
    logic tx_pop_empty, tx_push_full, rx_pop_empty, rx_push_full;
    logic [ERR_N-1:0] err_set;
    int unsigned sh;

    always_comb begin
        sh    = word_shift(st_q.ws);
        cap   = LVL_W'(FIFO_BYTES >> sh);
        flush = (word_sel != st_q.ws);
        for (int i = 0; i < DATA_W; i++) begin
            mask[i] = (i < (8 << sh));
        end
        err_set          = '0;
        err_set[ERR_OVF] = rx_push_full;
        err_set[ERR_UR]  = tx_pop_empty && framed_en;
        err_set[ERR_FRM] = sync_repeat;
        st_d     = st_q;
        st_d.ws  = word_sel;
        st_d.err = err_set | (st_q.err & ~err_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sfifo_queue #(.DEPTH(FIFO_BYTES), .DATA_W(DATA_W), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap), .mask(mask),
        .push(tx_wr), .push_data(tx_wr_data), .pop(tx_rd),
        .level(tx_lvl), .pop_data(tx_rd_data),
        .push_full(tx_push_full), .pop_empty(tx_pop_empty)
    );

    sfifo_queue #(.DEPTH(FIFO_BYTES), .DATA_W(DATA_W), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap), .mask(mask),
        .push(rx_wr), .push_data(rx_wr_data), .pop(rx_rd),
        .level(rx_lvl), .pop_data(rx_rd_data),
        .push_full(rx_push_full), .pop_empty(rx_pop_empty)
    );

    sfifo_irq_eval #(.IS_TX(1'b1), .LVL_W(LVL_W)) u_tx_eval (
        .lvl(tx_lvl), .cap(cap), .mode(tx_irq_mode), .idle(!tx_busy), .irq(tx_irq)
    );

    sfifo_irq_eval #(.IS_TX(1'b0), .LVL_W(LVL_W)) u_rx_eval (
        .lvl(rx_lvl), .cap(cap), .mode(rx_irq_mode), .idle(1'b1), .irq(rx_irq)
    );

    always_comb begin
        status                               = '0;
        status[ST_RXEMPTY]                   = (rx_lvl == '0);
        status[ST_OVF]                       = st_q.err[ERR_OVF];
        status[ST_UR]                        = st_q.err[ERR_UR];
        status[ST_FRM]                       = st_q.err[ERR_FRM];
        status[ST_TXLVL +: ST_LVL_W]         = ST_LVL_W'(tx_lvl);
        status[ST_RXLVL +: ST_LVL_W]         = ST_LVL_W'(rx_lvl);
        fault_irq                            = |(st_q.err & err_irq_en);
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err[ERR_OVF] && !err_clr[ERR_OVF]) |=> st_q.err[ERR_OVF]); // R7
    AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.err[ERR_OVF]) |-> $past(rx_wr)); // R7
    AST_UR_ONLY_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.err[ERR_UR]) |-> $past(framed_en && tx_rd)); // R8
    AST_FRM_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.err[ERR_FRM]) |-> $past(sync_repeat)); // R9
    AST_RX_FULL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq_mode == 2'd3 && rx_irq) |-> (rx_lvl == cap)); // R3
    AST_TX_QUIET_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq_mode == 2'd0 && tx_irq) |-> (!tx_busy && tx_lvl == '0)); // R4
    AST_FAULT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq_en == '0) |-> !fault_irq); // R10
endmodule

// File: tb/sfifo_irq_gen_tb_top.sv
module sfifo_irq_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  word_sel = '0;
    logic        framed_en = 1'b0;
    logic        tx_busy = 1'b0;
    logic [1:0]  tx_irq_mode = '0;
    logic [1:0]  rx_irq_mode = '0;
    logic [2:0]  err_irq_en = '0;
    logic [2:0]  err_clr = '0;
    logic        tx_wr = 1'b0;
    logic [31:0] tx_wr_data = '0;
    logic        tx_rd = 1'b0;
    logic [31:0] tx_rd_data;
    logic        rx_wr = 1'b0;
    logic [31:0] rx_wr_data = '0;
    logic        rx_rd = 1'b0;
    logic [31:0] rx_rd_data;
    logic        sync_repeat = 1'b0;
    logic [31:0] status;
    logic        tx_irq, rx_irq, fault_irq;

    int n_vec = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    logic [1:0]  ws_m = '0;
    bit ovf_m = 0, ur_m = 0, frm_m = 0;
    logic [31:0] txd_m = '0, rxd_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfifo_irq_gen dut_i (
        .clk(clk), .rst_n(rst_n), .word_sel(word_sel), .framed_en(framed_en),
        .tx_busy(tx_busy), .tx_irq_mode(tx_irq_mode), .rx_irq_mode(rx_irq_mode),
        .err_irq_en(err_irq_en), .err_clr(err_clr),
        .tx_wr(tx_wr), .tx_wr_data(tx_wr_data), .tx_rd(tx_rd), .tx_rd_data(tx_rd_data),
        .rx_wr(rx_wr), .rx_wr_data(rx_wr_data), .rx_rd(rx_rd), .rx_rd_data(rx_rd_data),
        .sync_repeat(sync_repeat), .status(status),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .fault_irq(fault_irq)
    );

    function automatic int cap_of(input logic [1:0] ws);
        return (ws == 2'd0) ? 16 : (ws == 2'd1) ? 8 : 4;
    endfunction

    function automatic logic [31:0] mask_of(input logic [1:0] ws);
        return (ws == 2'd0) ? 32'h0000_00FF : (ws == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic bit exp_rx_irq(input logic [1:0] m, input int l, input int c);
        case (m)
            2'd0:    return l == 0;
            2'd1:    return l != 0;
            2'd2:    return l >= c / 2;
            default: return l == c;
        endcase
    endfunction

    function automatic bit exp_tx_irq(input logic [1:0] m, input int l, input int c, input bit busy);
        case (m)
            2'd0:    return (l == 0) && !busy;
            2'd1:    return l == 0;
            2'd2:    return (c - l) >= c / 2;
            default: return l < c;
        endcase
    endfunction

    function automatic logic [31:0] exp_status();
        logic [31:0] s;
        s = '0;
        s[5]     = (rxq.size() == 0);
        s[6]     = ovf_m;
        s[8]     = ur_m;
        s[12]    = frm_m;
        s[20:16] = 5'(txq.size());
        s[28:24] = 5'(rxq.size());
        return s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        bit s_ovf, s_ur;
        int c;
        s_ovf = 0;
        s_ur  = 0;
        c     = cap_of(ws_m);
        if (word_sel != ws_m) begin
            txq.delete();
            rxq.delete();
        end else begin
            int tl, rl;
            tl = txq.size();
            rl = rxq.size();
            if (tx_rd) begin
                if (tl > 0) txd_m = txq.pop_front();
                else if (framed_en) s_ur = 1;
            end
            if (tx_wr && tl < c) txq.push_back(tx_wr_data & mask_of(ws_m));
            if (rx_rd && rl > 0) rxd_m = rxq.pop_front();
            if (rx_wr) begin
                if (rl < c) rxq.push_back(rx_wr_data & mask_of(ws_m));
                else s_ovf = 1;
            end
        end
        ovf_m = s_ovf | (ovf_m & !err_clr[0]);
        ur_m  = s_ur | (ur_m & !err_clr[1]);
        frm_m = sync_repeat | (frm_m & !err_clr[2]);
        ws_m  = word_sel;
    endtask

    task automatic compare_all();
        int c;
        c = cap_of(ws_m);
        chk("R1 transmit level", 32'(status[20:16]), 32'(txq.size()));
        chk("R1 receive level", 32'(status[28:24]), 32'(rxq.size()));
        chk("R2 status word", status, exp_status());
        chk("R7 overflow flag", 32'(status[6]), 32'(ovf_m));
        chk("R8 underrun flag", 32'(status[8]), 32'(ur_m));
        chk("R9 frame error flag", 32'(status[12]), 32'(frm_m));
        chk("R3 rx_irq", 32'(rx_irq), 32'(exp_rx_irq(rx_irq_mode, rxq.size(), c)));
        chk("R4 tx_irq", 32'(tx_irq), 32'(exp_tx_irq(tx_irq_mode, txq.size(), c, tx_busy)));
        chk("R10 fault_irq", 32'(fault_irq), 32'(|({frm_m, ur_m, ovf_m} & err_irq_en)));
        chk("R5 tx_rd_data", tx_rd_data, txd_m);
        chk("R5 rx_rd_data", rx_rd_data, rxd_m);
    endtask

    task automatic cycle();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic quiet();
        tx_wr = 0; tx_rd = 0; rx_wr = 0; rx_rd = 0;
        err_clr = '0; sync_repeat = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired before the run ended");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int p_push, p_pop;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R12 status after reset", status, 32'h0000_0020);
        chk("R12 tx_rd_data after reset", tx_rd_data, 32'h0);
        chk("R12 rx_rd_data after reset", rx_rd_data, 32'h0);
        chk("R12 fault_irq after reset", 32'(fault_irq), 32'h0);

        // 32-bit words: capacity 4, overflow, empty pop
        err_irq_en = 3'b001;
        rx_irq_mode = 2'd3;
        word_sel = 2'd2;
        cycle();
        for (int i = 0; i < 5; i++) begin
            rx_wr = 1; rx_wr_data = 32'd100 + 32'(i);
            cycle();
        end
        quiet();
        chk("R1 receive capacity 4 at 32-bit", 32'(status[28:24]), 32'd4);
        chk("R7 overflow on full push", 32'(status[6]), 32'd1);
        chk("R10 fault from overflow", 32'(fault_irq), 32'd1);
        for (int i = 0; i < 4; i++) begin
            rx_rd = 1;
            cycle();
        end
        chk("R5 fourth word out", rx_rd_data, 32'd103);
        cycle();
        quiet();
        chk("R6 empty pop keeps data", rx_rd_data, 32'd103);
        chk("R6 empty pop keeps level", 32'(status[28:24]), 32'd0);
        err_clr = 3'b001;
        cycle();
        quiet();
        chk("R7 overflow cleared", 32'(status[6]), 32'd0);

        // 8-bit words: masking
        word_sel = 2'd0;
        cycle();
        tx_wr = 1; tx_wr_data = 32'hABCD_EF12;
        cycle();
        quiet();
        tx_rd = 1;
        cycle();
        quiet();
        chk("R5 data masked to 8 bits", tx_rd_data, 32'h0000_0012);

        // flush on word size change, flags kept
        sync_repeat = 1;
        cycle();
        quiet();
        for (int i = 0; i < 3; i++) begin
            tx_wr = 1; tx_wr_data = 32'(i);
            cycle();
        end
        chk("R1 three entries queued", 32'(status[20:16]), 32'd3);
        word_sel = 2'd1;
        cycle();
        quiet();
        chk("R11 flush empties transmit", 32'(status[20:16]), 32'd0);
        chk("R11 flush keeps frame flag", 32'(status[12]), 32'd1);
        err_clr = 3'b100;
        cycle();
        quiet();
        chk("R9 frame flag cleared", 32'(status[12]), 32'd0);

        // underrun only in framed mode
        framed_en = 0; tx_rd = 1;
        cycle();
        quiet();
        chk("R8 no underrun unframed", 32'(status[8]), 32'd0);
        framed_en = 1; tx_rd = 1;
        cycle();
        quiet();
        chk("R8 underrun when framed", 32'(status[8]), 32'd1);

        // constrained random
        p_push = 50; p_pop = 50;
        for (int n = 0; n < N_RANDOM; n++) begin
            if (n % 150 == 0) begin
                case ($urandom % 3)
                    0: begin p_push = 85; p_pop = 15; end
                    1: begin p_push = 50; p_pop = 50; end
                    default: begin p_push = 15; p_pop = 85; end
                endcase
                framed_en  = 1'($urandom);
                err_irq_en = 3'($urandom);
            end
            if (n % 20 == 0) begin
                tx_irq_mode = 2'($urandom);
                rx_irq_mode = 2'($urandom);
            end
            if ($urandom % 80 == 0) word_sel = 2'($urandom);
            tx_busy     = 1'($urandom);
            tx_wr       = ($urandom % 100) < p_push;
            rx_wr       = ($urandom % 100) < p_push;
            tx_rd       = ($urandom % 100) < p_pop;
            rx_rd       = ($urandom % 100) < p_pop;
            tx_wr_data  = $urandom;
            rx_wr_data  = $urandom;
            sync_repeat = ($urandom % 50) == 0;
            err_clr     = {($urandom % 30) == 0, ($urandom % 30) == 0, ($urandom % 30) == 0};
            cycle();
        end
        quiet();
        cycle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule